// File: doc/BRIEF.md
# Auto-Request Memory-to-Memory DMA Channel

This block is one memory-to-memory DMA channel. Software sets it up through a small register port. It writes a source address, a destination address, a transfer count and a channel control word. A separate operation register holds a master enable that covers the whole DMA unit. Once software starts the channel in auto-request mode, the block moves data on its own. It runs a series of read-then-write cycles on a simple request/ready memory master port. Each transfer moves one byte or one 16-bit word.

After each transfer, each address moves by its own rule: it stays fixed, it counts up, or it counts down. The step is one for bytes and two for words. The count register counts down once per transfer. When the last write has been acknowledged, the block clears the channel enable bit and raises `done` for one cycle. Software then reads the updated addresses and a count of zero back through the register port. While a transfer runs, writes to the address, count and control registers are dropped, so the running transfer cannot be disturbed.

Top module: `mem_dma_chan`

## Requirements
- R1: After reset, every register reads zero, `mem_req` is low and `done` is low.
- R2: Register offsets are as follows. Source address is at 0x40 and destination address is at 0x44, each 32 bits wide. The count sits in bits 15:0 at 0x48, and the operation register sits in bits 31:16 of the same word. Channel control sits in bits 15:0 at 0x4C. Each `reg_be` bit enables one byte lane. The count register holds CNT_W bits, and reads return it zero-extended. `reg_rdata` is combinational from `reg_addr` while `reg_en` is high.
- R3: A transfer starts only on a write that changes channel control or the operation register. It starts if, with the written values, all three of these hold:
  - channel enable (control bit 0) is 1;
  - master enable (operation bit 0) is 1;
  - the request source field (control bits 11:8) is 0xC.
  Otherwise no memory request is made and the control register keeps its value.
- R4: Each transfer is one read on the source address, followed by one write of the returned data on the destination address. A request stays asserted with a stable address and direction until `mem_ready`. The next read starts only after the write has been acknowledged.
- R5: Control bit 3 = 1 selects 16-bit words, with strobes 11 and the full data. Control bit 3 = 0 selects bytes. In byte mode the read lane comes from source address bit 0, and the write goes to the lane given by destination address bit 0 with a single strobe. Lane 0 is data bits 7:0 (even address); lane 1 is bits 15:8.
- R6: Control bits 15:14 set the destination address mode and bits 13:12 set the source address mode. The codes are: 00 fixed, 01 increment, 10 decrement, 11 fixed. The step is 2 in word mode and 1 in byte mode. The address registers hold the stepped addresses during the transfer and after it ends.
- R7: A transfer makes exactly N read/write pairs, where N is the count value and 0 means 2^CNT_W. The count register drops by one per pair and reads 0 at the end.
- R8: On the cycle after the last write acknowledge, control bit 0 reads 0 and `done` is high for exactly one cycle.
- R9: While a transfer runs, writes to the source, destination, count and control registers are ignored.
- R10: No memory request is made while the channel is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_en | input | 1 | Register access select |
| reg_we | input | 1 | Register write (1) or read (0) |
| reg_addr | input | REG_AW | Register byte offset, word aligned |
| reg_be | input | 4 | Byte enables for register writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_strb | output | 2 | Write byte strobes |
| mem_wdata | output | 16 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request; read data valid |
| mem_rdata | input | 16 | Memory read data |
| done | output | 1 | One-cycle pulse when a transfer completes |

## Verification
The bench runs transfers with odd byte addresses in both directions. A wrong lane choice would then show up as swapped bytes or a strobe on the wrong half. It also runs the fixed codes 00 and 11 and the decrement mode at word size, which catch a step that is not doubled or an encoding that is read wrongly. A zero count must run the full 2^CNT_W pairs. A design that treats zero as "nothing to do", or that stops one pair early or late, leaves writes missing or extra in the scoreboard and a non-zero count at the end. Further runs cover a wrong request source, a master enable that is off, a start launched by writing the operation register, and register writes made in the middle of a busy transfer. A design that ignored the start gating, or that let those writes through, would issue stray requests or end with corrupted addresses.

// File: rtl/dma_chan_pkg.sv
// Package: shared offsets, control-field positions, state and mode types,
// and a byte-lane merge helper for the DMA channel.
package dma_chan_pkg;

    localparam logic [7:0] OFF_SRC   = 8'h40;
    localparam logic [7:0] OFF_DST   = 8'h44;
    localparam logic [7:0] OFF_CNTOP = 8'h48;
    localparam logic [7:0] OFF_CTRL  = 8'h4C;

    localparam int CB_EN    = 0;
    localparam int CB_WORD  = 3;
    localparam int CB_RS_LO = 8;
    localparam int CB_SM_LO = 12;
    localparam int CB_DM_LO = 14;
    localparam int OB_MASTER = 0;

    localparam logic [3:0] RS_AUTO = 4'hC;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_READ  = 2'd1,
        SEQ_WRITE = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        AM_FIX0 = 2'd0,
        AM_INC  = 2'd1,
        AM_DEC  = 2'd2,
        AM_FIX3 = 2'd3
    } addr_mode_e;

    // Replace the byte lanes of old_v selected by be with those of new_v.
    function automatic logic [31:0] merge_bytes(input logic [31:0] old_v,
                                                 input logic [31:0] new_v,
                                                 input logic [3:0]  be);
        logic [31:0] r;
        r = old_v;
        for (int i = 0; i < 4; i++) begin
            if (be[i]) r[8*i +: 8] = new_v[8*i +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/dma_addr_step.sv
// Module: dma_addr_step
// Computes the next value of one transfer address from its 2-bit mode
// (fixed / increment / decrement / fixed) and the transfer size.
// Assumes: pure combinational, wraps modulo 2^AW.
module dma_addr_step
    import dma_chan_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur,
    input  logic [1:0]    mode,
    input  logic          word,
    output logic [AW-1:0] nxt
);

    logic [AW-1:0] stride;

    // Select the stride from the transfer size and apply the mode.
    always_comb begin
        stride = word ? AW'(2) : AW'(1);
        case (addr_mode_e'(mode))
            AM_INC:  nxt = cur + stride;
            AM_DEC:  nxt = cur - stride;
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/dma_regs.sv
// Module: dma_regs
// Register file of the channel: source, destination, count, control and
// the operation register. Decodes register writes, produces the start
// strobe and takes address/count updates from the sequencer.
// Assumes: word-aligned offsets; writes to source, destination, count
// and control are dropped while busy; the operation register is always
// writable.
module dma_regs
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [3:0]        reg_be,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              src_adv,
    input  logic              dst_adv,
    input  logic              cnt_dec,
    input  logic              finish,
    input  logic [ADDR_W-1:0] src_next,
    input  logic [ADDR_W-1:0] dst_next,
    output logic [ADDR_W-1:0] sar,
    output logic [ADDR_W-1:0] dar,
    output logic [CNT_W-1:0]  tcr,
    output logic [15:0]       ctrl,
    output logic              start
);

    logic [ADDR_W-1:0] sar_q, dar_q;
    logic [CNT_W-1:0]  tcr_q;
    logic [15:0]       ctrl_q, op_q;

    logic        wr_any, hit_src, hit_dst, hit_cntop, hit_ctrl;
    logic        wr_src, wr_dst, wr_cnt, wr_op, wr_ctrl;
    logic [31:0] src_m, dst_m, cntop_m, ctrl_m;
    logic [15:0] ctrl_eval, op_eval;

    // Decode the register write and merge byte lanes into each register.
    always_comb begin
        wr_any    = reg_en & reg_we;
        hit_src   = wr_any && (reg_addr == REG_AW'(OFF_SRC));
        hit_dst   = wr_any && (reg_addr == REG_AW'(OFF_DST));
        hit_cntop = wr_any && (reg_addr == REG_AW'(OFF_CNTOP));
        hit_ctrl  = wr_any && (reg_addr == REG_AW'(OFF_CTRL));
        wr_src    = hit_src && !busy;
        wr_dst    = hit_dst && !busy;
        wr_cnt    = hit_cntop && (|reg_be[1:0]) && !busy;
        wr_op     = hit_cntop && (|reg_be[3:2]);
        wr_ctrl   = hit_ctrl && (|reg_be[1:0]) && !busy;
        src_m     = merge_bytes(32'(sar_q), reg_wdata, reg_be);
        dst_m     = merge_bytes(32'(dar_q), reg_wdata, reg_be);
        cntop_m   = merge_bytes({op_q, 16'(tcr_q)}, reg_wdata, reg_be);
        ctrl_m    = merge_bytes({16'h0000, ctrl_q}, reg_wdata, reg_be);
    end

    // Evaluate the start condition with the values being written.
    always_comb begin
        ctrl_eval = wr_ctrl ? ctrl_m[15:0] : ctrl_q;
        op_eval   = wr_op ? cntop_m[31:16] : op_q;
        start     = !busy && (wr_ctrl || wr_op)
                    && ctrl_eval[CB_EN] && op_eval[OB_MASTER]
                    && (ctrl_eval[CB_RS_LO +: 4] == RS_AUTO);
    end

    // Source address: sequencer step has priority over software write.
    always_ff @(posedge clk) begin
        if (!rst_n)       sar_q <= '0;
        else if (src_adv) sar_q <= src_next;
        else if (wr_src)  sar_q <= ADDR_W'(src_m);
    end

    // Destination address: sequencer step has priority over software write.
    always_ff @(posedge clk) begin
        if (!rst_n)       dar_q <= '0;
        else if (dst_adv) dar_q <= dst_next;
        else if (wr_dst)  dar_q <= ADDR_W'(dst_m);
    end

    // Transfer count: decrement per completed pair, else software load.
    always_ff @(posedge clk) begin
        if (!rst_n)       tcr_q <= '0;
        else if (cnt_dec) tcr_q <= tcr_q - CNT_W'(1);
        else if (wr_cnt)  tcr_q <= CNT_W'(cntop_m[15:0]);
    end

    // Operation register: master enable lives here.
    always_ff @(posedge clk) begin
        if (!rst_n)     op_q <= '0;
        else if (wr_op) op_q <= cntop_m[31:16];
    end

    // Channel control: cleared enable on finish, else software write.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (finish)  ctrl_q <= ctrl_q & ~(16'h0001 << CB_EN);
        else if (wr_ctrl) ctrl_q <= ctrl_m[15:0];
    end

    // Combinational read-back multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (reg_en && !reg_we) begin
            if (reg_addr == REG_AW'(OFF_SRC))        reg_rdata = 32'(sar_q);
            else if (reg_addr == REG_AW'(OFF_DST))   reg_rdata = 32'(dar_q);
            else if (reg_addr == REG_AW'(OFF_CNTOP)) reg_rdata = {op_q, 16'(tcr_q)};
            else if (reg_addr == REG_AW'(OFF_CTRL))  reg_rdata = {16'h0000, ctrl_q};
        end
    end

    assign sar  = sar_q;
    assign dar  = dar_q;
    assign tcr  = tcr_q;
    assign ctrl = ctrl_q;

endmodule

// File: rtl/dma_seq.sv
// Module: dma_seq
// Transfer sequencer: runs read-then-write pairs on the memory master
// port, picks byte lanes, and signals address/count updates and the end.
// Assumes: memory holds a request until mem_ready; read data is valid in
// the mem_ready cycle; the control word is stable while busy.
module dma_seq
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              word,
    input  logic [ADDR_W-1:0] sar,
    input  logic [ADDR_W-1:0] dar,
    input  logic [CNT_W-1:0]  tcr,
    input  logic              mem_ready,
    input  logic [15:0]       mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_strb,
    output logic [15:0]       mem_wdata,
    output logic              src_adv,
    output logic              dst_adv,
    output logic              cnt_dec,
    output logic              finish,
    output logic              busy,
    output logic              done
);

    seq_state_e state_q;
    logic [15:0] data_q;
    logic        last_pair;
    logic        done_q;

    // Handshake events and the end-of-transfer condition.
    always_comb begin
        last_pair = (tcr == CNT_W'(1));
        src_adv   = (state_q == SEQ_READ) && mem_ready;
        dst_adv   = (state_q == SEQ_WRITE) && mem_ready;
        cnt_dec   = dst_adv;
        finish    = dst_adv && last_pair;
        busy      = (state_q != SEQ_IDLE);
    end

    // Memory master outputs, with byte lane replication in byte mode.
    always_comb begin
        mem_req   = (state_q != SEQ_IDLE);
        mem_we    = (state_q == SEQ_WRITE);
        mem_addr  = (state_q == SEQ_WRITE) ? dar : sar;
        mem_wdata = word ? data_q : {data_q[7:0], data_q[7:0]};
        mem_strb  = word ? 2'b11 : (dar[0] ? 2'b10 : 2'b01);
    end

    // State register: idle -> read -> write -> read ... -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            case (state_q)
                SEQ_IDLE:  if (start) state_q <= SEQ_READ;
                SEQ_READ:  if (mem_ready) state_q <= SEQ_WRITE;
                SEQ_WRITE: if (mem_ready) state_q <= last_pair ? SEQ_IDLE : SEQ_READ;
                default:   state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Capture read data, selecting the source lane in byte mode.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (src_adv) data_q <= word ? mem_rdata
                                         : {8'h00, (sar[0] ? mem_rdata[15:8] : mem_rdata[7:0])};
    end

    // One-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= finish;
    end

    assign done = done_q;

endmodule

// File: rtl/mem_dma_chan.sv
// Module: mem_dma_chan (top)
// Single auto-request memory-to-memory DMA channel: register slave port,
// transfer sequencer, two address steppers and a 16-bit memory master.
// Assumes: ADDR_W <= 32, CNT_W <= 16, REG_AW >= 8; synchronous active-low
// reset.
module mem_dma_chan
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [3:0]        reg_be,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_strb,
    output logic [15:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [15:0]       mem_rdata,
    output logic              done
);

    localparam int N_ADDR = 2;

    logic [ADDR_W-1:0] sar_w, dar_w;
    logic [CNT_W-1:0]  tcr_w;
    logic [15:0]       ctrl_w;
    logic              start_w, busy_w, word_w;
    logic              src_adv_w, dst_adv_w, cnt_dec_w, finish_w;

    logic [ADDR_W-1:0] step_cur [N_ADDR];
    logic [ADDR_W-1:0] step_nxt [N_ADDR];
    logic [1:0]        step_mode [N_ADDR];

    assign word_w       = ctrl_w[CB_WORD];
    assign step_cur[0]  = sar_w;
    assign step_cur[1]  = dar_w;
    assign step_mode[0] = ctrl_w[CB_SM_LO +: 2];
    assign step_mode[1] = ctrl_w[CB_DM_LO +: 2];

    dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy_w), .src_adv(src_adv_w), .dst_adv(dst_adv_w),
        .cnt_dec(cnt_dec_w), .finish(finish_w),
        .src_next(step_nxt[0]), .dst_next(step_nxt[1]),
        .sar(sar_w), .dar(dar_w), .tcr(tcr_w), .ctrl(ctrl_w),
        .start(start_w)
    );

    // One stepper per address (source, destination).
    for (genvar g = 0; g < N_ADDR; g++) begin : g_step
        dma_addr_step #(.AW(ADDR_W)) u_step (
            .cur(step_cur[g]), .mode(step_mode[g]),
            .word(word_w), .nxt(step_nxt[g])
        );
    end

    dma_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start_w), .word(word_w),
        .sar(sar_w), .dar(dar_w), .tcr(tcr_w),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_strb(mem_strb), .mem_wdata(mem_wdata),
        .src_adv(src_adv_w), .dst_adv(dst_adv_w), .cnt_dec(cnt_dec_w),
        .finish(finish_w), .busy(busy_w), .done(done)
    );

endmodule

// File: rtl/mem_dma_chan_chk.sv
// Module: mem_dma_chan_chk
// Protocol and state checks for mem_dma_chan, attached by bind below.
// Assumes: sampled on the rising edge, disabled during reset.
module mem_dma_chan_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        mem_strb,
    input logic              mem_ready,
    input logic              done,
    input logic              busy,
    input logic              src_adv,
    input logic [ADDR_W-1:0] sar,
    input logic              ctrl_en,
    input logic              word
);

    // R4: a pending request keeps address and direction until ready.
    p_hold_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R4: an accepted read is followed by the write of the same pair.
    p_wr_after_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready) |=> (mem_req && mem_we));

    // R5: byte writes carry exactly one strobe.
    p_byte_strb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !word) |-> ($countones(mem_strb) == 1));

    // R5: word writes carry both strobes.
    p_word_strb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && word) |-> (mem_strb == 2'b11));

    // R8: the completion pulse lasts one cycle.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: channel enable is already clear when done is seen.
    p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ctrl_en);

    // R9: while busy the source address only moves on a read handshake.
    p_sar_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !src_adv) |=> $stable(sar));

    // R10: completion leaves the memory port quiet.
    p_idle_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

endmodule

bind mem_dma_chan mem_dma_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_strb(mem_strb), .mem_ready(mem_ready), .done(done),
    .busy(busy_w), .src_adv(src_adv_w), .sar(sar_w),
    .ctrl_en(ctrl_w[0]), .word(ctrl_w[3])
);

// File: tb/sim_mem_dma_chan.sv
// Scoreboard bench for mem_dma_chan: the driver task predicts every write
// into a queue; the memory model pops and compares each accepted write.
module sim_mem_dma_chan;

    localparam int CNT_W = 8;
    localparam int NFULL = 1 << CNT_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [1:0]  mem_strb;
    logic [15:0] mem_wdata;
    logic        mem_ready = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        done;

    always #5 clk = ~clk;

    mem_dma_chan #(.ADDR_W(32), .CNT_W(CNT_W), .REG_AW(8)) u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_strb(mem_strb), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .done(done)
    );

    typedef struct {
        logic [7:0]  addr;
        logic [1:0]  strb;
        logic [15:0] data;
    } exp_t;

    exp_t       sb_q[$];
    logic [7:0] bmem [256];
    int         lat_cfg = 0;
    int         checks = 0, bad = 0;
    int         mon_checks = 0, mon_bad = 0;
    int         done_seen = 0, req_cycles = 0;

    // Memory model and scoreboard monitor, all on the falling edge.
    initial begin
        int wcnt;
        exp_t e;
        logic [15:0] mask;
        logic [7:0] a;
        wcnt = 0;
        for (int i = 0; i < 256; i++) bmem[i] = 8'((i * 37 + 11) ^ (i >> 3));
        forever begin
            @(negedge clk);
            if (done) done_seen++;
            if (mem_req) req_cycles++;
            if (mem_ready) wcnt = lat_cfg;
            if (mem_req && rst_n) begin
                if (wcnt > 0) begin
                    wcnt--;
                    mem_ready = 1'b0;
                end else begin
                    mem_ready = 1'b1;
                    a = mem_addr[7:0];
                    if (!mem_we) begin
                        mem_rdata = {bmem[a | 8'h01], bmem[a & 8'hFE]};
                    end else begin
                        if (mem_strb[0]) bmem[a & 8'hFE] = mem_wdata[7:0];
                        if (mem_strb[1]) bmem[a | 8'h01] = mem_wdata[15:8];
                        mon_checks++;
                        if (sb_q.size() == 0) begin
                            mon_bad++;
                            $display("FAIL R7 unexpected write actual addr=%h expected none", a);
                        end else begin
                            e = sb_q.pop_front();
                            mask = {{8{e.strb[1]}}, {8{e.strb[0]}}};
                            if (a !== e.addr || mem_strb !== e.strb ||
                                (mem_wdata & mask) !== (e.data & mask)) begin
                                mon_bad++;
                                $display("FAIL R5/R6 write actual a=%h s=%b d=%h expected a=%h s=%b d=%h",
                                         a, mem_strb, mem_wdata, e.addr, e.strb, e.data);
                            end
                        end
                    end
                end
            end else begin
                mem_ready = 1'b0;
                wcnt = lat_cfg;
            end
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0; reg_be = '0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_en = 1'b0;
    endtask

    function automatic logic [31:0] fstep(input logic [31:0] a, input logic [1:0] m, input bit w);
        logic [31:0] s;
        s = w ? 32'd2 : 32'd1;
        case (m)
            2'b01:   return a + s;
            2'b10:   return a - s;
            default: return a;
        endcase
    endfunction

    task automatic summary(input int extra);
        $display("  test done: total=%0d bad=%0d", checks + mon_checks + extra, bad + mon_bad + extra);
    endtask

    // Driver: predict the write stream, program the channel, check the end state.
    // how: 0 start by control write, 1 start by operation write, 2 busy pokes.
    task automatic run_xfer(input logic [31:0] s, input logic [31:0] d, input int cnt,
                            input logic [1:0] sm, input logic [1:0] dm, input bit w,
                            input int lat, input int how, input string tag);
        int n, t, dstart, rq0;
        logic [31:0] ss, dd, rd;
        logic [15:0] cw;
        logic [7:0] b;
        exp_t e;
        n = (cnt == 0) ? NFULL : cnt;
        ss = s; dd = d;
        for (int i = 0; i < n; i++) begin
            if (w) begin
                e.addr = dd[7:0];
                e.strb = 2'b11;
                e.data = {bmem[ss[7:0] | 8'h01], bmem[ss[7:0] & 8'hFE]};
            end else begin
                b = bmem[ss[7:0]];
                e.addr = dd[7:0];
                e.strb = dd[0] ? 2'b10 : 2'b01;
                e.data = {b, b};
            end
            sb_q.push_back(e);
            ss = fstep(ss, sm, w);
            dd = fstep(dd, dm, w);
        end
        lat_cfg = lat;
        cw = {dm, sm, 4'hC, 4'h0, w, 3'b001};
        dstart = done_seen;
        reg_wr(8'h40, s, 4'b1111);
        reg_wr(8'h44, d, 4'b1111);
        reg_wr(8'h48, 32'(cnt), 4'b0011);
        if (how == 1) begin
            reg_wr(8'h48, 32'h0000_0000, 4'b1100);
            rq0 = req_cycles;
            reg_wr(8'h4C, 32'(cw), 4'b0011);
            repeat (10) @(negedge clk);
            chk({"R3 master off holds ", tag}, 32'(req_cycles), 32'(rq0));
            reg_rd(8'h4C, rd);
            chk({"R3 control kept ", tag}, rd, 32'(cw));
            reg_wr(8'h48, 32'h0001_0000, 4'b1100);
        end else begin
            reg_wr(8'h48, 32'h0001_0000, 4'b1100);
            reg_wr(8'h4C, 32'(cw), 4'b0011);
        end
        if (how == 2) begin
            repeat (3) @(negedge clk);
            reg_wr(8'h40, 32'hDEAD_BEEF, 4'b1111);
            reg_wr(8'h44, 32'h1234_5678, 4'b1111);
            reg_wr(8'h48, 32'h0000_0077, 4'b0011);
            reg_wr(8'h4C, 32'h0000_5C09, 4'b0011);
        end
        t = 0;
        while (done_seen == dstart && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk({"R8 done seen ", tag}, 32'(done_seen > dstart), 32'd1);
        rq0 = req_cycles;
        repeat (4) @(negedge clk);
        chk({"R8 single done ", tag}, 32'(done_seen - dstart), 32'd1);
        chk({"R10 idle no request ", tag}, 32'(req_cycles), 32'(rq0));
        chk({"R7 all writes made ", tag}, 32'(sb_q.size()), 32'd0);
        sb_q.delete();
        reg_rd(8'h40, rd);
        chk({"R6 final source ", tag}, rd, ss);
        reg_rd(8'h44, rd);
        chk({"R6 final dest ", tag}, rd, dd);
        reg_rd(8'h48, rd);
        chk({"R7 count zero ", tag}, rd, 32'h0001_0000);
        reg_rd(8'h4C, rd);
        chk({"R8 enable cleared ", tag}, rd, 32'(cw & 16'hFFFE));
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog actual=timeout expected=finish");
        summary(1);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int rq0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        reg_rd(8'h40, rd); chk("R1 source reset", rd, 32'h0);
        reg_rd(8'h44, rd); chk("R1 dest reset", rd, 32'h0);
        reg_rd(8'h48, rd); chk("R1 count/op reset", rd, 32'h0);
        reg_rd(8'h4C, rd); chk("R1 control reset", rd, 32'h0);
        chk("R1 mem_req low", 32'(mem_req), 32'h0);
        chk("R1 done low", 32'(done), 32'h0);
        // R2 register layout and byte enables
        reg_wr(8'h40, 32'h1234_5678, 4'b1111);
        reg_rd(8'h40, rd); chk("R2 source readback", rd, 32'h1234_5678);
        reg_wr(8'h40, 32'hAABB_CCDD, 4'b0100);
        reg_rd(8'h40, rd); chk("R2 byte enable merge", rd, 32'h12BB_5678);
        reg_wr(8'h48, 32'h0000_1234, 4'b0011);
        reg_rd(8'h48, rd); chk("R2 count width", rd, 32'h0000_0034);
        reg_wr(8'h48, 32'h00A0_0000, 4'b1100);
        reg_rd(8'h48, rd); chk("R2 op upper half", rd, 32'h00A0_0034);
        reg_wr(8'h48, 32'h0, 4'b1100);
        // Transfers
        run_xfer(32'h10, 32'h80, 4, 2'b01, 2'b01, 1'b1, 0, 0, "word inc/inc");
        run_xfer(32'h21, 32'hC5, 5, 2'b01, 2'b10, 1'b0, 1, 0, "byte inc/dec odd");
        run_xfer(32'h30, 32'h60, 3, 2'b11, 2'b01, 1'b0, 0, 0, "byte fix3/inc");
        run_xfer(32'h4E, 32'hA0, 3, 2'b10, 2'b00, 1'b1, 2, 0, "word dec/fix0");
        // R3 wrong request source: no transfer, control kept
        reg_wr(8'h48, 32'h0001_0000, 4'b1100);
        rq0 = req_cycles;
        reg_wr(8'h4C, 32'h0000_0501, 4'b0011);
        repeat (20) @(negedge clk);
        chk("R3 non-auto source idle", 32'(req_cycles), 32'(rq0));
        reg_rd(8'h4C, rd); chk("R3 control unchanged", rd, 32'h0000_0501);
        reg_wr(8'h4C, 32'h0, 4'b0011);
        run_xfer(32'h00, 32'hE0, 2, 2'b01, 2'b01, 1'b1, 0, 1, "start by op write");
        // R9 busy writes ignored
        run_xfer(32'h40, 32'h90, 6, 2'b01, 2'b01, 1'b0, 3, 2, "R9 busy pokes");
        // R7 zero count means 2^CNT_W pairs
        run_xfer(32'h05, 32'h00, 0, 2'b00, 2'b01, 1'b0, 0, 0, "R7 zero count");
        summary(0);
        $finish;
    end

endmodule